// File: doc/BRIEF.md
# Sound-CPU Address Decoder with Serial Bank Register

This block sits between an 8-bit sound processor and the devices it reaches through its 16-bit address space. It looks at each read or write strobe and decides the target. The targets are an 8 KB local RAM, the four ports of an FM synthesis chip, the data port of a programmable sound generator, and a 32 KB window into a 24-bit host address space. The RAM contents and the audio chips are outside the block. The block only drives their selects and steers read data back to the processor.

The host window is located by a 9-bit bank register. Software loads it one bit per write: each write to the bank address shifts data bit 0 in at the top. The host bus is 16 bits wide. A byte access through the window therefore uses a word address, picks one byte lane when reading, and copies the byte onto both lanes when writing. All decoding is combinational. Only the bank register is clocked.

Top module: `sndcpu_addr_decode`

## Requirements
- R1: An access with address bits 15:13 all zero (0x0000 to 0x1FFF) asserts `ram_cs`. A write also asserts `ram_we`. A read returns `ram_rdata` on `cpu_rdata`.
- R2: A read from any address 0x4000 to 0x4003 asserts `fm_rd` and returns `fm_status` on `cpu_rdata`.
- R3: A write to 0x4000 or 0x4002 asserts `fm_addr_we`, and `fm_reg_addr` is {address bit 1, write data}. That gives bit 8 = 0 for 0x4000 and 1 for 0x4002. A write to 0x4001 or 0x4003 asserts `fm_data_we`.
- R4: A write to 0x7F11, 0x7F13, 0x7F15 or 0x7F17 asserts `psg_we`. At most one target class is selected in any cycle.
- R5: A write to 0x6000 updates the 9-bit bank at the next rising clock edge. The new bank is {data bit 0, old bank bits 8:1}.
- R6: An access with address bit 15 set asserts `host_rd` or `host_we`, and `host_addr` = bank·2^15 + address bits 14:1 · 2, so bit 0 is always 0.
- R7: A window read returns `host_rdata[15:8]` for an even address and `host_rdata[7:0]` for an odd address.
- R8: A window write drives the write byte onto both halves of `host_wdata`.
- R9: A read from any unmapped address (0x2000 to 0x3FFF, 0x4004 to 0x7FFF, and any read of 0x6000 or of the sound-generator addresses) returns 0xFF. A write to an unmapped address asserts no select and leaves the bank unchanged.
- R10: Reset clears the bank to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Sound-CPU address |
| cpu_wdata | input | 8 | Sound-CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| ram_cs | output | 1 | Local RAM select |
| ram_we | output | 1 | Local RAM write enable |
| ram_rdata | input | 8 | Local RAM read data |
| fm_rd | output | 1 | FM status read |
| fm_addr_we | output | 1 | FM register-address write |
| fm_data_we | output | 1 | FM data write |
| fm_reg_addr | output | 9 | FM register address with the port-select bit on top |
| fm_status | input | 8 | FM status byte |
| psg_we | output | 1 | Sound-generator data write |
| host_rd | output | 1 | Host window read |
| host_we | output | 1 | Host window write |
| host_addr | output | 24 | Translated host byte address (word aligned) |
| host_wdata | output | 16 | Host write data, byte copied to both lanes |
| host_rdata | input | 16 | Host read word |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle, and that address and data stay stable for the whole cycle in which a strobe is high. If both strobes were high together, the window and RAM selects could describe a read and a write at once, and the single-target check would no longer mean anything. The bench changes every input on the falling edge only, raises one strobe at a time, and holds each write across exactly one rising edge. The bank therefore moves by exactly one bit per write.

// File: rtl/sndcpu_pkg.sv
package sndcpu_pkg;

  localparam int SND_AW  = 16;
  localparam int SND_DW  = 8;
  localparam int BANK_W  = 9;
  localparam int WIN_AW  = 15;
  localparam int HOST_AW = BANK_W + WIN_AW;
  localparam int HOST_DW = 2 * SND_DW;

  localparam logic [SND_AW-1:0] BANK_PORT = 16'h6000;
  localparam logic [12:0]       PSG_HI13  = 13'h0FE2; // 0x7F10..0x7F17
  localparam logic [13:0]       FM_HI14   = 14'h1000; // 0x4000..0x4003

  typedef enum logic [2:0] {
    RG_NONE, RG_RAM, RG_FM, RG_BANK, RG_PSG, RG_WIN
  } region_e;

  // Target of an access at addr; some targets exist for writes only.
  function automatic region_e classify(input logic [SND_AW-1:0] addr,
                                       input logic is_wr);
    region_e r;
    r = RG_NONE;
    if (addr[15])                              r = RG_WIN;
    else if (addr[15:13] == 3'b000)            r = RG_RAM;
    else if (addr[15:2] == FM_HI14)            r = RG_FM;
    else if (is_wr && addr == BANK_PORT)       r = RG_BANK;
    else if (is_wr && addr[15:3] == PSG_HI13 && addr[0]) r = RG_PSG;
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] bank_shift(input logic [BANK_W-1:0] b,
                                                   input logic bit_in);
    return {bit_in, b[BANK_W-1:1]};
  endfunction

  function automatic logic [HOST_AW-1:0] win_addr(input logic [BANK_W-1:0] b,
                                                  input logic [WIN_AW-1:0] a);
    return {b, a[WIN_AW-1:1], 1'b0};
  endfunction

  function automatic logic [SND_DW-1:0] lane_pick(input logic [HOST_DW-1:0] w,
                                                  input logic odd);
    return odd ? w[SND_DW-1:0] : w[HOST_DW-1:SND_DW];
  endfunction

endpackage

// File: rtl/sndcpu_region_dec.sv
module sndcpu_region_dec
  import sndcpu_pkg::*;
#(
  parameter int AW = SND_AW
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output region_e       rd_region,
  output logic          ram_cs,
  output logic          ram_we,
  output logic          fm_rd,
  output logic          fm_addr_we,
  output logic          fm_data_we,
  output logic          psg_we,
  output logic          bank_we,
  output logic          win_rd,
  output logic          win_we
);
  region_e wr_region;

  always_comb begin
    rd_region = classify(addr, 1'b0);
    wr_region = classify(addr, 1'b1);
  end

  always_comb begin
    ram_cs     = (rd && rd_region == RG_RAM) || (wr && wr_region == RG_RAM);
    ram_we     = wr && wr_region == RG_RAM;
    fm_rd      = rd && rd_region == RG_FM;
    fm_addr_we = wr && wr_region == RG_FM && !addr[0];
    fm_data_we = wr && wr_region == RG_FM &&  addr[0];
    psg_we     = wr && wr_region == RG_PSG;
    bank_we    = wr && wr_region == RG_BANK;
    win_rd     = rd && rd_region == RG_WIN;
    win_we     = wr && wr_region == RG_WIN;
  end
endmodule

// File: rtl/sndcpu_bank_sr.sv
module sndcpu_bank_sr
  import sndcpu_pkg::*;
#(
  parameter int BW = BANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [BW-1:0] bank
);
  logic [BW-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bank_q <= '0;
    else if (shift_en) bank_q <= bank_shift(bank_q, bit_in);
  end

  assign bank = bank_q;

  // R5: new bit lands at the top, the rest moves down one place
  a_r5_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bank_q[BW-1] == $past(bit_in));
  a_r5_move_down: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bank_q[BW-2:0] == $past(bank_q[BW-1:1]));
  // R9: anything other than a bank write leaves it alone
  a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(bank_q));
endmodule

// File: rtl/sndcpu_win_map.sv
module sndcpu_win_map
  import sndcpu_pkg::*;
#(
  parameter int BW  = BANK_W,
  parameter int WAW = WIN_AW,
  parameter int DW  = SND_DW,
  localparam int HAW = BW + WAW,
  localparam int HDW = 2 * DW
) (
  input  logic [BW-1:0]  bank,
  input  logic [WAW-1:0] win_off,
  input  logic [DW-1:0]  wbyte,
  input  logic [HDW-1:0] host_word,
  output logic [HAW-1:0] host_addr,
  output logic [HDW-1:0] host_wdata,
  output logic [DW-1:0]  lane_byte
);
  always_comb begin
    host_addr  = win_addr(bank, win_off);
    host_wdata = {wbyte, wbyte};
    lane_byte  = lane_pick(host_word, win_off[0]);
  end
endmodule

// File: rtl/sndcpu_addr_decode.sv
module sndcpu_addr_decode
  import sndcpu_pkg::*;
#(
  parameter int AW  = SND_AW,
  parameter int DW  = SND_DW,
  parameter int BW  = BANK_W,
  parameter int WAW = WIN_AW,
  localparam int HAW = BW + WAW,
  localparam int HDW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  input  logic           cpu_rd,
  input  logic           cpu_wr,
  output logic [DW-1:0]  cpu_rdata,
  output logic           ram_cs,
  output logic           ram_we,
  input  logic [DW-1:0]  ram_rdata,
  output logic           fm_rd,
  output logic           fm_addr_we,
  output logic           fm_data_we,
  output logic [DW:0]    fm_reg_addr,
  input  logic [DW-1:0]  fm_status,
  output logic           psg_we,
  output logic           host_rd,
  output logic           host_we,
  output logic [HAW-1:0] host_addr,
  output logic [HDW-1:0] host_wdata,
  input  logic [HDW-1:0] host_rdata
);
  region_e       rd_region;
  logic          bank_we;
  logic [BW-1:0] bank;
  logic [DW-1:0] lane_byte;

  sndcpu_region_dec #(.AW(AW)) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .rd_region(rd_region),
    .ram_cs(ram_cs), .ram_we(ram_we), .fm_rd(fm_rd),
    .fm_addr_we(fm_addr_we), .fm_data_we(fm_data_we), .psg_we(psg_we),
    .bank_we(bank_we), .win_rd(host_rd), .win_we(host_we)
  );

  sndcpu_bank_sr #(.BW(BW)) u_bank (
    .clk(clk), .rst_n(rst_n), .shift_en(bank_we), .bit_in(cpu_wdata[0]),
    .bank(bank)
  );

  sndcpu_win_map #(.BW(BW), .WAW(WAW), .DW(DW)) u_win (
    .bank(bank), .win_off(cpu_addr[WAW-1:0]), .wbyte(cpu_wdata),
    .host_word(host_rdata), .host_addr(host_addr), .host_wdata(host_wdata),
    .lane_byte(lane_byte)
  );

  assign fm_reg_addr = {cpu_addr[1], cpu_wdata};

  always_comb begin
    unique case (rd_region)
      RG_RAM:  cpu_rdata = ram_rdata;
      RG_FM:   cpu_rdata = fm_status;
      RG_WIN:  cpu_rdata = lane_byte;
      default: cpu_rdata = '1;
    endcase
  end

  // R4: one target class per cycle
  a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_cs, fm_rd | fm_addr_we | fm_data_we, psg_we,
              host_rd | host_we, bank_we}));
  // R6: host word alignment
  a_r6_even_host: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_we) |-> host_addr[0] == 1'b0);
  // R8: both host lanes carry the same byte
  a_r8_dup_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> host_wdata[HDW-1:DW] == host_wdata[DW-1:0]);
  // R9: reads that hit nothing return all ones
  a_r9_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !ram_cs && !fm_rd && !host_rd) |-> cpu_rdata == '1);
endmodule

// File: tb/tb_sndcpu_addr_decode.sv
module tb_sndcpu_addr_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        ram_cs, ram_we, fm_rd, fm_addr_we, fm_data_we, psg_we;
  logic        host_rd, host_we;
  logic [8:0]  fm_reg_addr;
  logic [23:0] host_addr;
  logic [15:0] host_wdata;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [7:0]  fm_status = 8'hC3;
  logic [15:0] host_rdata = 16'h1234;

  int checks = 0, errors = 0;
  logic [8:0] mbank;

  always #2 clk = ~clk;

  sndcpu_addr_decode dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_rdata(ram_rdata),
    .fm_rd(fm_rd), .fm_addr_we(fm_addr_we), .fm_data_we(fm_data_we),
    .fm_reg_addr(fm_reg_addr), .fm_status(fm_status), .psg_we(psg_we),
    .host_rd(host_rd), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  // {addr, rd, wr, wdata, sel{ram_cs,ram_we,fm_rd,fm_aw,fm_dw,psg,h_rd,h_we}, rdata, fm_reg}
  localparam int VW = 51;
  localparam int NV = 19;
  localparam logic [VW-1:0] VECS [NV] = '{
    {16'h0000, 1'b1, 1'b0, 8'h00, 8'b1000_0000, 8'h5A, 9'h000}, // R1
    {16'h1FFF, 1'b0, 1'b1, 8'hA5, 8'b1100_0000, 8'hFF, 9'h000}, // R1
    {16'h0000, 1'b0, 1'b0, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // no strobe
    {16'h2000, 1'b1, 1'b0, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // R9
    {16'h4000, 1'b1, 1'b0, 8'h00, 8'b0010_0000, 8'hC3, 9'h000}, // R2
    {16'h4003, 1'b1, 1'b0, 8'h00, 8'b0010_0000, 8'hC3, 9'h000}, // R2
    {16'h4004, 1'b1, 1'b0, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // R9
    {16'h4000, 1'b0, 1'b1, 8'h27, 8'b0001_0000, 8'hFF, 9'h027}, // R3
    {16'h4002, 1'b0, 1'b1, 8'h2B, 8'b0001_0000, 8'hFF, 9'h12B}, // R3
    {16'h4001, 1'b0, 1'b1, 8'h11, 8'b0000_1000, 8'hFF, 9'h000}, // R3
    {16'h4003, 1'b0, 1'b1, 8'h22, 8'b0000_1000, 8'hFF, 9'h000}, // R3
    {16'h7F11, 1'b0, 1'b1, 8'h90, 8'b0000_0100, 8'hFF, 9'h000}, // R4
    {16'h7F17, 1'b0, 1'b1, 8'h9F, 8'b0000_0100, 8'hFF, 9'h000}, // R4
    {16'h7F13, 1'b1, 1'b0, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // R9
    {16'h7F12, 1'b0, 1'b1, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // R9
    {16'h7F19, 1'b0, 1'b1, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}, // R9
    {16'h8000, 1'b1, 1'b0, 8'h00, 8'b0000_0010, 8'h12, 9'h000}, // R7
    {16'h8001, 1'b1, 1'b0, 8'h00, 8'b0000_0010, 8'h34, 9'h000}, // R7
    {16'h6000, 1'b1, 1'b0, 8'h00, 8'b0000_0000, 8'hFF, 9'h000}  // R9
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w,
                       input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    #1;
  endtask

  task automatic bank_write(input logic [7:0] d);
    drive(16'h6000, 1'b0, 1'b1, d);
    mbank = {d[0], mbank[8:1]};
  endtask

  function automatic logic [23:0] exp_host(input logic [8:0] b,
                                           input logic [15:0] a);
    return (24'(b) << 15) + 24'(a & 16'h7FFE);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mbank = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: bank starts at zero
    drive(16'hFFFE, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'h007FFE, "R10 host_addr after reset");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [7:0] sel;
      v = VECS[i];
      drive(v[50:35], v[34], v[33], v[32:25]);
      sel = {ram_cs, ram_we, fm_rd, fm_addr_we, fm_data_we, psg_we,
             host_rd, host_we};
      check(32'(sel), 32'(v[24:17]), $sformatf("R1-table sel addr %h", v[50:35]));
      if (v[34])
        check(32'(cpu_rdata), 32'(v[16:9]), $sformatf("R9-table rdata addr %h", v[50:35]));
      if (v[24:17] == 8'b0001_0000)
        check(32'(fm_reg_addr), 32'(v[8:0]), "R3 fm_reg_addr");
    end

    // R5: serial bank loading, one bit per write
    bank_write(8'h01);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'(exp_host(mbank, 16'h8000)), "R5 first bit");
    bank_write(8'h00); bank_write(8'hFF); bank_write(8'h03);
    bank_write(8'h02); bank_write(8'h00); bank_write(8'h81);
    bank_write(8'h10); bank_write(8'h01);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'(exp_host(mbank, 16'h8000)), "R5 nine bits");
    bank_write(8'hFE);
    drive(16'hC357, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'(exp_host(mbank, 16'hC357)), "R6 odd offset");
    check(32'(cpu_rdata), 32'h34, "R7 odd lane");

    // R9: unmapped write leaves bank and selects alone
    drive(16'h5000, 1'b0, 1'b1, 8'hFF);
    check(32'({ram_cs, fm_addr_we, fm_data_we, psg_we, host_we}), 32'h0,
          "R9 unmapped write selects");
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'(exp_host(mbank, 16'h8000)), "R9 bank unchanged");

    // R8: window write duplicates the byte
    drive(16'h8ABC, 1'b0, 1'b1, 8'h3C);
    check(32'(host_wdata), 32'h3C3C, "R8 host_wdata");
    check(32'(host_addr), 32'(exp_host(mbank, 16'h8ABC)), "R6 write addr");

    // R10: reset mid-run clears the bank
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    rst_n = 1'b0;
    #1;
    check(32'(host_addr), 32'h0, "R10 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    mbank = '0;
    bank_write(8'h01);
    drive(16'h8000, 1'b1, 1'b0, 8'h00);
    check(32'(host_addr), 32'h800000, "R5 after reset");

    drive(16'h0000, 1'b0, 1'b0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule